// File: doc/BRIEF.md
# Byte-Serial Reflected CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a byte stream. It folds one byte into the running remainder on every clock cycle in which a byte is presented. Processing is reflected, so each byte is consumed from its least significant bit upward. A select input picks one of two generator polynomials: the IEEE one or the Castagnoli one. The remainder is complemented when a message begins and complemented again when the result is published, so zero bytes at the front of a message still alter the checksum.

A message opens with a start pulse. The start pulse loads the remainder from zero, or from a supplied seed when the seed enable is set. The polynomial choice is captured at the same moment. Because the output complement cancels the next load complement, a finished CRC can be fed back as the seed. The engine then carries on as if the two messages had been one. The byte marked last produces a registered result one cycle later, together with a single-cycle done flag.

Top module: `crc32_byte_engine`

## Requirements
- R1: While reset is held and after it is released, `crc_o` reads 0x00000000 and `done_o` reads 0.
- R2: With `poly_sel_i` = 0 the engine uses the reflected generator 0xEDB88320, which is 0x104C11DB7 in normal form with the top bit shown. Bits of each byte are consumed LSB first. Bytes 0x48 0x69 0x0A give 0xD5223C9A, and ASCII "123456789" gives 0xCBF43926.
- R3: With `poly_sel_i` = 1 the engine uses the reflected generator 0x82F63B78. ASCII "123456789" gives 0xE3069283.
- R4: `poly_sel_i` is sampled only in the cycle that `start_i` is high. Changing it later in the message has no effect on the result.
- R5: A start with `seed_en_i` = 0 begins from an all-ones remainder, which is the complement of zero. Prefixing a message with a zero byte therefore changes its CRC.
- R6: A start with `seed_en_i` = 1 begins from the complement of `seed_i`. Seeding with the CRC of message s and then feeding t yields the CRC of s followed by t.
- R7: Cycles with `byte_vld_i` = 0 and `start_i` = 0 leave the remainder unchanged, so idle gaps inside a message do not alter the result.
- R8: One cycle after a byte accepted with `last_i` = 1, `done_o` is high for exactly that cycle. `crc_o` then shows the complemented remainder and holds it until the next completion.
- R9: A byte presented in the same cycle as `start_i` is folded into the freshly loaded remainder, so a one-byte message fits in a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new message; loads the remainder and captures the polynomial |
| seed_en_i | input | 1 | At start, take the initial value from `seed_i` instead of zero |
| seed_i | input | 32 | Previously finished CRC to continue from |
| poly_sel_i | input | 1 | 0 selects IEEE, 1 selects Castagnoli; sampled at start |
| byte_vld_i | input | 1 | `byte_i` carries a message byte this cycle |
| byte_i | input | 8 | Message byte |
| last_i | input | 1 | Qualifies the current valid byte as the final one of the message |
| crc_o | output | 32 | Registered finished CRC |
| done_o | output | 1 | One-cycle pulse marking a new value on `crc_o` |

## Verification
On every cycle, the assertions check four things. The captured polynomial and the remainder stay still when nothing is started or fed. The output value stays still between completions. Every done pulse traces back to a last byte. A zero combined byte reduces the fold to a plain shift. Whether the arithmetic produces the right checksum for each polynomial can only be shown by the bench's scenarios. The same holds for the effect of a leading zero byte, for correct chaining through the seed, and for a start coinciding with a byte. The bench compares against published check values and against its own bit-serial model.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;

    typedef enum logic {
        POLY_IEEE = 1'b0,
        POLY_CAST = 1'b1
    } poly_sel_e;

    localparam logic [CRC_W-1:0] POLY_IEEE_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] POLY_CAST_REFL = 32'h82F6_3B78;

    typedef struct packed {
        logic [CRC_W-1:0] rem;
        poly_sel_e        sel;
    } crc_ctx_t;

    function automatic logic [CRC_W-1:0] poly_const(input poly_sel_e sel);
        return (sel == POLY_CAST) ? POLY_CAST_REFL : POLY_IEEE_REFL;
    endfunction

endpackage

// File: rtl/crc32_byte_fold.sv
module crc32_byte_fold
    import crc32_pkg::*;
#(
    parameter int W  = CRC_W,
    parameter int BW = BYTE_W
) (
    input  logic [W-1:0]  rem_i,
    input  logic [BW-1:0] byte_i,
    input  logic [W-1:0]  poly_i,
    output logic [W-1:0]  rem_o
);
    localparam int STAGES = BW;

    logic [W-1:0] chain [0:STAGES];

    assign chain[0] = rem_i ^ {{(W-BW){1'b0}}, byte_i};

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_bit
            assign chain[g+1] = chain[g][0] ? ((chain[g] >> 1) ^ poly_i)
                                            : (chain[g] >> 1);
        end
    endgenerate

    assign rem_o = chain[STAGES];

    always_comb begin
        if ((rem_i[BW-1:0] ^ byte_i) == '0) begin
            assert_zero_index_shift_R2: assert (rem_o == (rem_i >> BW))
                else $error("zero combined byte must reduce to a plain shift");
        end
    end
endmodule

// File: rtl/crc32_state_reg.sv
module crc32_state_reg
    import crc32_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       seed_en_i,
    input  logic [W-1:0] seed_i,
    input  poly_sel_e  poly_sel_i,
    input  logic       byte_vld_i,
    input  logic [W-1:0] folded_i,
    output logic [W-1:0] base_o,
    output poly_sel_e  sel_o
);
    crc_ctx_t ctx_q;
    logic [W-1:0] load_val;

    assign load_val = ~(seed_en_i ? seed_i : '0);
    assign base_o   = start_i ? load_val   : ctx_q.rem;
    assign sel_o    = start_i ? poly_sel_i : ctx_q.sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q.rem <= '1;
            ctx_q.sel <= POLY_IEEE;
        end else begin
            if (start_i) ctx_q.sel <= poly_sel_i;
            if (byte_vld_i)   ctx_q.rem <= folded_i;
            else if (start_i) ctx_q.rem <= load_val;
        end
    end

    assert_poly_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(ctx_q.sel));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !byte_vld_i) |=> $stable(ctx_q.rem));

    assert_seed_load_R6: assert property (@(posedge clk) disable iff (rst)
        (start_i && seed_en_i && !byte_vld_i) |=> (ctx_q.rem == ~$past(seed_i)));
endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
    import crc32_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        seed_en_i,
    input  logic [31:0] seed_i,
    input  logic        poly_sel_i,
    input  logic        byte_vld_i,
    input  logic [7:0]  byte_i,
    input  logic        last_i,
    output logic [31:0] crc_o,
    output logic        done_o
);
    logic [CRC_W-1:0] base_rem;
    logic [CRC_W-1:0] folded_rem;
    poly_sel_e        act_sel;
    logic [CRC_W-1:0] crc_q;
    logic             done_q;

    crc32_state_reg #(.W(CRC_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .seed_en_i  (seed_en_i),
        .seed_i     (seed_i),
        .poly_sel_i (poly_sel_e'(poly_sel_i)),
        .byte_vld_i (byte_vld_i),
        .folded_i   (folded_rem),
        .base_o     (base_rem),
        .sel_o      (act_sel)
    );

    crc32_byte_fold #(.W(CRC_W), .BW(BYTE_W)) u_fold (
        .rem_i  (base_rem),
        .byte_i (byte_i),
        .poly_i (poly_const(act_sel)),
        .rem_o  (folded_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= byte_vld_i && last_i;
            if (byte_vld_i && last_i) crc_q <= ~folded_rem;
        end
    end

    assign crc_o  = crc_q;
    assign done_o = done_q;

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(crc_o));

    assert_done_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (!(byte_vld_i && last_i)) |=> !done_o);
endmodule

// File: tb/test_crc32_byte_engine.sv
module test_crc32_byte_engine;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, seed_en_i, poly_sel_i, byte_vld_i, last_i;
    logic [31:0] seed_i;
    logic [7:0]  byte_i;
    logic [31:0] crc_o;
    logic        done_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] msg [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    crc32_byte_engine i_crc32_byte_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .seed_en_i(seed_en_i),
        .seed_i(seed_i), .poly_sel_i(poly_sel_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .last_i(last_i), .crc_o(crc_o), .done_o(done_o)
    );

    function automatic logic [31:0] model(input logic cast, input logic [31:0] init,
                                          input int len);
        logic [31:0] r = ~init;
        logic [31:0] p = cast ? 32'h82F63B78 : 32'hEDB88320;
        for (int i = 0; i < len; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb = r[0] ^ msg[i][k];
                r = r >> 1;
                if (fb) r = r ^ p;
            end
        end
        return ~r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_digits(input int from, input int n);
        for (int i = 0; i < n; i++) msg[i] = 8'h31 + 8'(from + i);
    endtask

    task automatic idle_inputs();
        start_i = 0; seed_en_i = 0; seed_i = '0; byte_vld_i = 0;
        byte_i = '0; last_i = 0;
    endtask

    task automatic feed(input logic cast, input logic use_seed, input logic [31:0] seed,
                        input int len, input int gap, input logic flip,
                        output logic [31:0] got, output logic dn1, output logic dn2);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            start_i    = (i == 0);
            seed_en_i  = (i == 0) && use_seed;
            seed_i     = seed;
            poly_sel_i = (flip && i > 0) ? ~cast : cast;
            byte_vld_i = 1;
            byte_i     = msg[i];
            last_i     = (i == len - 1);
            if (i != len - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    start_i = 0; byte_vld_i = 0; byte_i = 8'hA5;
                    poly_sel_i = flip ? ~cast : cast;
                end
            end
        end
        @(negedge clk);
        idle_inputs();
        got = crc_o;
        dn1 = done_o;
        @(negedge clk);
        dn2 = done_o;
    endtask

    task automatic t_reset();
        idle_inputs(); poly_sel_i = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 crc in reset", crc_o, 32'h0);
        chk("R1 done in reset", {31'b0, done_o}, 32'h0);
        rst = 0;
        @(negedge clk);
        chk("R1 crc after reset", crc_o, 32'h0);
    endtask

    task automatic t_ieee();
        logic [31:0] c; logic d1, d2;
        msg[0] = 8'h48; msg[1] = 8'h69; msg[2] = 8'h0A;
        feed(0, 0, 0, 3, 0, 0, c, d1, d2);
        chk("R2 Hi-newline IEEE", c, 32'hD5223C9A);
        chk("R8 done pulse", {31'b0, d1}, 32'h1);
        chk("R8 done drops", {31'b0, d2}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R8 crc holds", crc_o, 32'hD5223C9A);
        load_digits(0, 9);
        feed(0, 0, 0, 9, 0, 0, c, d1, d2);
        chk("R2 digits IEEE", c, 32'hCBF43926);
    endtask

    task automatic t_cast();
        logic [31:0] c; logic d1, d2;
        load_digits(0, 9);
        feed(1, 0, 0, 9, 0, 0, c, d1, d2);
        chk("R3 digits Castagnoli", c, 32'hE3069283);
    endtask

    task automatic t_poly_latch();
        logic [31:0] c; logic d1, d2;
        load_digits(0, 9);
        feed(1, 0, 0, 9, 0, 1, c, d1, d2);
        chk("R4 select flipped mid-message (Castagnoli)", c, 32'hE3069283);
        feed(0, 0, 0, 9, 1, 1, c, d1, d2);
        chk("R4 select flipped mid-message (IEEE)", c, 32'hCBF43926);
    endtask

    task automatic t_leading_zero();
        logic [31:0] c; logic d1, d2;
        msg[0] = 8'h00; msg[1] = 8'h48; msg[2] = 8'h69; msg[3] = 8'h0A;
        feed(0, 0, 0, 4, 0, 0, c, d1, d2);
        chk("R5 leading zero model", c, model(0, 32'h0, 4));
        chk("R5 leading zero differs", {31'b0, c == 32'hD5223C9A}, 32'h0);
    endtask

    task automatic t_seed();
        logic [31:0] c, s; logic d1, d2;
        load_digits(0, 4);
        feed(0, 0, 0, 4, 0, 0, s, d1, d2);
        load_digits(4, 5);
        feed(0, 1, s, 5, 0, 0, c, d1, d2);
        chk("R6 IEEE chained", c, 32'hCBF43926);
        load_digits(0, 6);
        feed(1, 0, 0, 6, 0, 0, s, d1, d2);
        load_digits(6, 3);
        feed(1, 1, s, 3, 2, 0, c, d1, d2);
        chk("R6 Castagnoli chained", c, 32'hE3069283);
    endtask

    task automatic t_gaps();
        logic [31:0] c; logic d1, d2;
        load_digits(0, 9);
        feed(0, 0, 0, 9, 3, 0, c, d1, d2);
        chk("R7 idle gaps IEEE", c, 32'hCBF43926);
        chk("R8 done after gapped message", {31'b0, d1}, 32'h1);
    endtask

    task automatic t_single();
        logic [31:0] c; logic d1, d2;
        msg[0] = 8'h5C;
        feed(1, 0, 0, 1, 0, 0, c, d1, d2);
        chk("R9 one-byte Castagnoli", c, model(1, 32'h0, 1));
        msg[0] = 8'h00;
        feed(0, 1, 32'h1234_5678, 1, 0, 0, c, d1, d2);
        chk("R9 one-byte seeded IEEE", c, model(0, 32'h1234_5678, 1));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ieee();
        t_cast();
        t_poly_latch();
        t_leading_zero();
        t_seed();
        t_gaps();
        t_single();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule